// File: doc/BRIEF.md
# Row-Column Parity Block Codec

The block protects a rectangular block of data bits with two-dimensional even parity. The encoder takes one data row per clock and forwards it with a row parity bit attached. After the last data row it emits one extra row that carries the column parities. The decoder takes such a block one row per clock and stores it. It recomputes every row check and every column check. It then releases the data rows one per clock, repairing bits where failing rows meet failing columns.

A data-bit error makes one row check and one column check fail, and the bit at that crossing is inverted. A failure in a row check alone points at that row's parity bit, so the data passes unchanged and is reported separately. Several data errors are repaired when the number of failing rows equals the number of failing columns. In that case the k-th failing row, counted from row 0 upward, is paired with the k-th failing column, counted from column 0 upward. Any other mix of failures leaves the block untouched and marks it uncorrectable. Each block raises exactly one of four status flags alongside its first output row.

Both paths use a valid/ready handshake. In every row word, bit COLS is the row parity bit and bits COLS-1:0 are the data bits, with column c at bit c. In the column-parity row, bits COLS-1:0 are the column parities. Its bit COLS is the even parity over all row parity bits, and the decoder ignores that bit.

Top module: `rcp_codec`

## Requirements
- R1: Each data row leaves the encoder in the same cycle it is offered, as `{p, data}`, where p makes the whole word even (p = XOR of the data bits).
- R2: After every ROWS accepted data rows, the encoder emits one parity row with `enc_last_o` high and `enc_ready_o` low. Bit c (c < COLS) of that row is the XOR of column c over that block's rows only. Bit COLS is the XOR of that block's row parity bits. The row is held stable while `enc_ready_i` is low.
- R3: The decoder accepts exactly ROWS+1 rows per block: the data rows first, then the column-parity row. `dec_ready_o` is low while the block drains. `dec_valid_o` rises in the cycle after the last input row is accepted. ROWS data rows then follow in order, each held stable until `dec_ready_i` accepts it.
- R4: With no failing check, the data rows come out unchanged and `no_error_o` is raised.
- R5: A single data-bit error, at row r and column c, is inverted back in the output and `corrected_o` is raised.
- R6: Exactly one failing row check with no failing column check leaves the data unchanged and raises `parity_err_o`.
- R7: With n ≥ 2 failing rows and n failing columns, the k-th failing row and the k-th failing column (both in ascending order) have their crossing bit inverted. All such crossings are repaired and `corrected_o` is raised.
- R8: With any other combination of failing rows and columns, the received data is output unmodified and `uncorrectable_o` is raised. Combinations covered include: failing columns with no failing row, and row and column failure counts that differ.
- R9: The four status flags are never active together. One of them is high only while the first output row of a block is valid, and it stays high until that row is accepted. The flags are low on all other rows.
- R10: During and right after reset, `dec_valid_o`, `enc_last_o` and all status flags are low, and `dec_ready_o` is high. With `enc_valid_i` low, `enc_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| enc_valid_i | input | 1 | encoder data row valid |
| enc_ready_o | output | 1 | encoder takes the offered row |
| enc_data_i | input | COLS | encoder data row |
| enc_valid_o | output | 1 | encoded row valid |
| enc_ready_i | input | 1 | downstream takes the encoded row |
| enc_row_o | output | COLS+1 | encoded row, parity in bit COLS |
| enc_last_o | output | 1 | current encoded row is the column-parity row |
| dec_valid_i | input | 1 | received row valid |
| dec_ready_o | output | 1 | decoder takes the received row |
| dec_row_i | input | COLS+1 | received row |
| dec_valid_o | output | 1 | decoded data row valid |
| dec_ready_i | input | 1 | downstream takes the decoded row |
| dec_data_o | output | COLS | decoded (repaired) data row |
| no_error_o | output | 1 | block had no failing check |
| corrected_o | output | 1 | data bits were repaired |
| parity_err_o | output | 1 | only one row parity bit was bad |
| uncorrectable_o | output | 1 | block left unmodified, errors not locatable |

## Verification
In the encoder, two things can happen in the same cycle. The parity row of one block is being output while the first row of the next block is already offered at the input. That row must be refused, and the column accumulator must start afresh when it is finally taken. The bench provokes this by encoding all table blocks back to back, keeping `enc_valid_i` high through every parity-row cycle. It then checks each following block's parity row against parities the bench computes itself. In the decoder, the first output row and its status flag coincide, and a stall on that row must hold both. Alternate blocks stall `dec_ready_i`, and the flag is checked on every cycle of the first row.

// File: rtl/rcp_pkg.sv
package rcp_pkg;
  typedef enum logic [1:0] {
    CLS_CLEAN  = 2'd0,
    CLS_DATA   = 2'd1,
    CLS_PARITY = 2'd2,
    CLS_FAIL   = 2'd3
  } rcp_class_e;
endpackage

// File: rtl/rcp_encoder.sv
module rcp_encoder #(
  parameter int ROWS = 8,
  parameter int COLS = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  output logic            ready_o,
  input  logic [COLS-1:0] data_i,
  output logic            valid_o,
  input  logic            ready_i,
  output logic [COLS:0]   row_o,
  output logic            last_o
);
  localparam int CW = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic            par_q;
  logic [CW-1:0]   cnt_q;
  logic [COLS-1:0] col_q;
  logic            rp_q;
  logic            row_par;
  logic            data_fire;
  logic            first_row;

  assign row_par   = ^data_i;
  assign first_row = (cnt_q == '0);
  assign data_fire = valid_i & ~par_q & ready_i;

  assign ready_o = ~par_q & ready_i;
  assign valid_o = par_q | valid_i;
  assign row_o   = par_q ? {rp_q, col_q} : {row_par, data_i};
  assign last_o  = par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_q <= 1'b0;
      cnt_q <= '0;
      col_q <= '0;
      rp_q  <= 1'b0;
    end else if (data_fire) begin
      // accumulators restart on the first row of each block
      col_q <= first_row ? data_i  : (col_q ^ data_i);
      rp_q  <= first_row ? row_par : (rp_q ^ row_par);
      if (cnt_q == CW'(ROWS - 1)) begin
        cnt_q <= '0;
        par_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (par_q && ready_i) begin
      par_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rcp_dec_store.sv
module rcp_dec_store #(
  parameter int ROWS = 8,
  parameter int COLS = 7
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  output logic                      ready_o,
  input  logic [COLS:0]             row_i,
  input  logic                      release_i,
  output logic                      full_o,
  output logic [ROWS-1:0][COLS-1:0] buf_o,
  output logic [ROWS-1:0]           rfail_o,
  output logic [COLS-1:0]           csyn_o
);
  localparam int IW = $clog2(ROWS + 1);

  logic            full_q;
  logic [IW-1:0]   idx_q;
  logic [COLS-1:0] csyn_q;
  logic            fire;
  logic            par_row;

  assign ready_o = ~full_q;
  assign fire    = valid_i & ~full_q;
  assign par_row = (idx_q == IW'(ROWS));
  assign full_o  = full_q;
  assign csyn_o  = csyn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      idx_q  <= '0;
      csyn_q <= '0;
    end else if (fire) begin
      csyn_q <= (idx_q == '0) ? row_i[COLS-1:0] : (csyn_q ^ row_i[COLS-1:0]);
      if (par_row) begin
        idx_q  <= '0;
        full_q <= 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end else if (release_i) begin
      full_q <= 1'b0;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [COLS-1:0] data_q;
    logic            fail_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q <= '0;
        fail_q <= 1'b0;
      end else if (fire && idx_q == IW'(r)) begin
        data_q <= row_i[COLS-1:0];
        fail_q <= ^row_i;
      end
    end
    assign buf_o[r]   = data_q;
    assign rfail_o[r] = fail_q;
  end
endmodule

// File: rtl/rcp_locator.sv
module rcp_locator
  import rcp_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 7
) (
  input  logic [ROWS-1:0]           rfail_i,
  input  logic [COLS-1:0]           csyn_i,
  output rcp_class_e                cls_o,
  output logic [ROWS-1:0][COLS-1:0] flip_o
);
  localparam int MX = (ROWS > COLS) ? ROWS : COLS;
  localparam int NW = $clog2(MX + 1);

  logic [NW-1:0] rrank [ROWS];
  logic [NW-1:0] crank [COLS];
  logic [NW-1:0] nr, nc;

  // rank = number of failing lines below this one
  always_comb begin
    nr = '0;
    for (int r = 0; r < ROWS; r++) begin
      rrank[r] = nr;
      nr = nr + NW'(rfail_i[r]);
    end
  end

  always_comb begin
    nc = '0;
    for (int c = 0; c < COLS; c++) begin
      crank[c] = nc;
      nc = nc + NW'(csyn_i[c]);
    end
  end

  always_comb begin
    if (nr == '0 && nc == '0)         cls_o = CLS_CLEAN;
    else if (nr == NW'(1) && nc == '0) cls_o = CLS_PARITY;
    else if (nr == nc)                cls_o = CLS_DATA;
    else                              cls_o = CLS_FAIL;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_fr
    for (genvar c = 0; c < COLS; c++) begin : g_fc
      assign flip_o[r][c] = (cls_o == CLS_DATA) & rfail_i[r] & csyn_i[c] &
                            (rrank[r] == crank[c]);
    end
  end
endmodule

// File: rtl/rcp_codec.sv
module rcp_codec
  import rcp_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            enc_valid_i,
  output logic            enc_ready_o,
  input  logic [COLS-1:0] enc_data_i,
  output logic            enc_valid_o,
  input  logic            enc_ready_i,
  output logic [COLS:0]   enc_row_o,
  output logic            enc_last_o,
  input  logic            dec_valid_i,
  output logic            dec_ready_o,
  input  logic [COLS:0]   dec_row_i,
  output logic            dec_valid_o,
  input  logic            dec_ready_i,
  output logic [COLS-1:0] dec_data_o,
  output logic            no_error_o,
  output logic            corrected_o,
  output logic            parity_err_o,
  output logic            uncorrectable_o
);
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic                      full;
  logic                      release_blk;
  logic [ROWS-1:0][COLS-1:0] blk;
  logic [ROWS-1:0][COLS-1:0] flip;
  logic [ROWS-1:0]           rfail;
  logic [COLS-1:0]           csyn;
  rcp_class_e                cls;
  logic [RW-1:0]             oidx_q;
  logic                      out_fire;
  logic                      out_last;
  logic                      first_out;

  rcp_encoder #(.ROWS(ROWS), .COLS(COLS)) u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (enc_valid_i),
    .ready_o (enc_ready_o),
    .data_i  (enc_data_i),
    .valid_o (enc_valid_o),
    .ready_i (enc_ready_i),
    .row_o   (enc_row_o),
    .last_o  (enc_last_o)
  );

  rcp_dec_store #(.ROWS(ROWS), .COLS(COLS)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (dec_valid_i),
    .ready_o   (dec_ready_o),
    .row_i     (dec_row_i),
    .release_i (release_blk),
    .full_o    (full),
    .buf_o     (blk),
    .rfail_o   (rfail),
    .csyn_o    (csyn)
  );

  rcp_locator #(.ROWS(ROWS), .COLS(COLS)) u_loc (
    .rfail_i (rfail),
    .csyn_i  (csyn),
    .cls_o   (cls),
    .flip_o  (flip)
  );

  assign out_fire    = full & dec_ready_i;
  assign out_last    = (oidx_q == RW'(ROWS - 1));
  assign release_blk = out_fire & out_last;
  assign first_out   = full & (oidx_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       oidx_q <= '0;
    else if (out_fire) oidx_q <= out_last ? '0 : (oidx_q + 1'b1);
  end

  assign dec_valid_o     = full;
  assign dec_data_o      = blk[oidx_q] ^ flip[oidx_q];
  assign no_error_o      = first_out & (cls == CLS_CLEAN);
  assign corrected_o     = first_out & (cls == CLS_DATA);
  assign parity_err_o    = first_out & (cls == CLS_PARITY);
  assign uncorrectable_o = first_out & (cls == CLS_FAIL);
endmodule

// File: rtl/rcp_codec_chk.sv
module rcp_codec_chk #(
  parameter int COLS = 7
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            enc_valid_o,
  input logic            enc_ready_o,
  input logic            enc_ready_i,
  input logic            enc_last_o,
  input logic [COLS:0]   enc_row_o,
  input logic            dec_valid_o,
  input logic            dec_ready_o,
  input logic            dec_ready_i,
  input logic [COLS-1:0] dec_data_o,
  input logic            no_error_o,
  input logic            corrected_o,
  input logic            parity_err_o,
  input logic            uncorrectable_o
);
  logic [3:0] flags;
  assign flags = {no_error_o, corrected_o, parity_err_o, uncorrectable_o};

  // R1
  row_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_valid_o && !enc_last_o |-> (^enc_row_o) == 1'b0);

  // R2
  par_no_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_last_o |-> !enc_ready_o);

  // R2
  par_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_last_o && !enc_ready_i |=> enc_last_o && $stable(enc_row_o));

  // R3
  no_take_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> !dec_ready_o);

  // R3
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && !dec_ready_i |=> dec_valid_o && $stable(dec_data_o));

  // R9
  flag_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flags));

  // R9
  flag_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags != 4'b0) |-> dec_valid_o);

  // R9
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags != 4'b0) && !dec_ready_i |=> $stable(flags));
endmodule

bind rcp_codec rcp_codec_chk #(.COLS(COLS)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .enc_valid_o     (enc_valid_o),
  .enc_ready_o     (enc_ready_o),
  .enc_ready_i     (enc_ready_i),
  .enc_last_o      (enc_last_o),
  .enc_row_o       (enc_row_o),
  .dec_valid_o     (dec_valid_o),
  .dec_ready_o     (dec_ready_o),
  .dec_ready_i     (dec_ready_i),
  .dec_data_o      (dec_data_o),
  .no_error_o      (no_error_o),
  .corrected_o     (corrected_o),
  .parity_err_o    (parity_err_o),
  .uncorrectable_o (uncorrectable_o)
);

// File: tb/tb_rcp_codec.sv
module tb_rcp_codec;
  localparam int ROWS = 8;
  localparam int COLS = 7;
  localparam int NV   = 13;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            enc_valid_i = 1'b0;
  logic            enc_ready_o;
  logic [COLS-1:0] enc_data_i = '0;
  logic            enc_valid_o;
  logic            enc_ready_i = 1'b1;
  logic [COLS:0]   enc_row_o;
  logic            enc_last_o;
  logic            dec_valid_i = 1'b0;
  logic            dec_ready_o;
  logic [COLS:0]   dec_row_i = '0;
  logic            dec_valid_o;
  logic            dec_ready_i = 1'b0;
  logic [COLS-1:0] dec_data_o;
  logic            no_error_o, corrected_o, parity_err_o, uncorrectable_o;

  always #10 clk = ~clk;

  rcp_codec #(.ROWS(ROWS), .COLS(COLS)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .enc_valid_i(enc_valid_i), .enc_ready_o(enc_ready_o), .enc_data_i(enc_data_i),
    .enc_valid_o(enc_valid_o), .enc_ready_i(enc_ready_i), .enc_row_o(enc_row_o),
    .enc_last_o(enc_last_o),
    .dec_valid_i(dec_valid_i), .dec_ready_o(dec_ready_o), .dec_row_i(dec_row_i),
    .dec_valid_o(dec_valid_o), .dec_ready_i(dec_ready_i), .dec_data_o(dec_data_o),
    .no_error_o(no_error_o), .corrected_o(corrected_o), .parity_err_o(parity_err_o),
    .uncorrectable_o(uncorrectable_o)
  );

  // error slot: {enable, row[3:0], col[2:0]}; cls 0 clean, 1 data, 2 parity, 3 fail
  typedef struct packed {
    logic [55:0] data;
    logic [7:0]  e0;
    logic [7:0]  e1;
    logic [7:0]  e2;
    logic [1:0]  cls;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{56'h00000000000000, 8'h00, 8'h00, 8'h00, 2'd0},
    '{56'hA55AF00F33CC7E, 8'h00, 8'h00, 8'h00, 2'd0},
    '{56'h123456789ABCDE, 8'h9C, 8'h00, 8'h00, 2'd1},
    '{56'hFFFFFFFFFFFFFF, 8'h80, 8'h00, 8'h00, 2'd1},
    '{56'h0F0F0F0F0F0F0F, 8'hBE, 8'h00, 8'h00, 2'd1},
    '{56'h13579BDF02468A, 8'hAF, 8'h00, 8'h00, 2'd2},
    '{56'hDEADBEEFCAFE12, 8'h8A, 8'hA5, 8'h00, 2'd1},
    '{56'h55555555555555, 8'h81, 8'h9B, 8'hB6, 2'd1},
    '{56'h89ABCDEF012345, 8'h91, 8'h94, 8'h00, 2'd3},
    '{56'h77777777777777, 8'hC3, 8'h00, 8'h00, 2'd3},
    '{56'h0123456789ABCD, 8'h8A, 8'hAA, 8'h00, 2'd3},
    '{56'hFEDCBA98765432, 8'h93, 8'hB7, 8'h00, 2'd3},
    '{56'hC3C3C3C3C3C3C3, 8'hC7, 8'h00, 8'h00, 2'd0}
  };

  int checks = 0;
  int failures = 0;

  logic [COLS:0]   enc_all [NV][ROWS+1];
  logic [COLS:0]   rx [ROWS+1];
  logic [COLS-1:0] got [ROWS];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit hit(input logic [7:0] e, input int r, input int c);
    return e[7] && (e[6:3] == r[3:0]) && (e[2:0] == c[2:0]);
  endfunction

  // encode one block; hold keeps the next block's first row offered during the parity row
  task automatic encode(input int vi, input logic [55:0] nxt, input bit hold, input bit pstall);
    int r = 0;
    int n = 0;
    int st = 0;
    logic [55:0]     d = VECS[vi].data;
    logic [COLS-1:0] cp = '0;
    logic            rp = 1'b0;
    logic [COLS:0]   held = '0;
    while (n < ROWS + 1) begin
      @(negedge clk);
      if (r < ROWS) begin
        enc_valid_i = 1'b1;
        enc_data_i  = d[r*COLS +: COLS];
      end else begin
        enc_valid_i = hold;
        enc_data_i  = nxt[0 +: COLS];
      end
      enc_ready_i = !(pstall && enc_last_o && st < 2);
      #1;
      if (enc_last_o) begin
        chk(!enc_ready_o, "R2 ready low on parity row", 64'(enc_ready_o), 64'd0);
        if (!enc_ready_i) begin
          if (st > 0) chk(enc_row_o == held, "R2 parity row held", 64'(enc_row_o), 64'(held));
          held = enc_row_o;
          st++;
        end
      end
      if (enc_valid_o && enc_ready_i) begin
        enc_all[vi][n] = enc_row_o;
        n++;
      end
      if (enc_valid_i && enc_ready_o) r++;
    end
    for (int k = 0; k < ROWS; k++) begin
      logic [COLS-1:0] dr = d[k*COLS +: COLS];
      chk(enc_all[vi][k] == {^dr, dr}, "R1 encoded row", 64'(enc_all[vi][k]), 64'({^dr, dr}));
      cp ^= dr;
      rp ^= ^dr;
    end
    chk(enc_all[vi][ROWS] == {rp, cp}, "R2 column parity row",
        64'(enc_all[vi][ROWS]), 64'({rp, cp}));
  endtask

  task automatic decode(input int vi, input bit stall);
    vec_t v = VECS[vi];
    int idx = 0;
    int cyc = 0;
    int nerr = 0;
    logic [3:0] expf;
    logic [3:0] actf;
    string tag;
    for (int r = 0; r <= ROWS; r++)
      for (int c = 0; c <= COLS; c++)
        rx[r][c] = enc_all[vi][r][c] ^ (hit(v.e0, r, c) | hit(v.e1, r, c) | hit(v.e2, r, c));
    nerr = int'(v.e0[7]) + int'(v.e1[7]) + int'(v.e2[7]);
    case (v.cls)
      2'd0: begin expf = 4'b1000; tag = "R4"; end
      2'd1: begin expf = 4'b0100; tag = (nerr == 1) ? "R5" : "R7"; end
      2'd2: begin expf = 4'b0010; tag = "R6"; end
      default: begin expf = 4'b0001; tag = "R8"; end
    endcase
    for (int k = 0; k <= ROWS; k++) begin
      @(negedge clk);
      dec_valid_i = 1'b1;
      dec_row_i   = rx[k];
      #1;
      if (k == 0 || k == ROWS)
        chk(dec_ready_o && !dec_valid_o, "R3 collecting", 64'({dec_ready_o, dec_valid_o}), 64'b10);
    end
    while (idx < ROWS && cyc < 64) begin
      @(negedge clk);
      dec_valid_i = 1'b0;
      dec_row_i   = '0;
      dec_ready_i = !(stall && (cyc % 3 == 0));
      #1;
      chk(dec_valid_o && !dec_ready_o, "R3 draining", 64'({dec_valid_o, dec_ready_o}), 64'b10);
      actf = {no_error_o, corrected_o, parity_err_o, uncorrectable_o};
      if (idx == 0) chk(actf == expf, "R9 status on first row", 64'(actf), 64'(expf));
      else          chk(actf == 4'b0, "R9 status low later", 64'(actf), 64'd0);
      if (dec_ready_i) begin
        got[idx] = dec_data_o;
        idx++;
      end
      cyc++;
    end
    for (int r = 0; r < ROWS; r++) begin
      logic [COLS-1:0] exp = v.data[r*COLS +: COLS];
      if (v.cls != 2'd1)
        for (int c = 0; c < COLS; c++) exp[c] = exp[c] ^ rx[r][c] ^ enc_all[vi][r][c];
      chk(got[r] == exp, {tag, " output row"}, 64'(got[r]), 64'(exp));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #5;
    chk(!dec_valid_o && dec_ready_o && !enc_valid_o && !enc_last_o,
        "R10 in reset", 64'({dec_valid_o, dec_ready_o, enc_valid_o, enc_last_o}), 64'b0100);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk({no_error_o, corrected_o, parity_err_o, uncorrectable_o} == 4'b0 && !dec_valid_o && dec_ready_o,
        "R10 after reset", 64'({no_error_o, corrected_o, parity_err_o, uncorrectable_o, dec_valid_o, dec_ready_o}),
        64'b000001);
    chk(!enc_valid_o && !enc_last_o, "R10 encoder idle", 64'({enc_valid_o, enc_last_o}), 64'd0);

    // back-to-back encode: next block's first row is already offered during each parity row
    for (int i = 0; i < NV; i++)
      encode(i, VECS[(i + 1) % NV].data, i < NV - 1, i == 4);

    for (int i = 0; i < NV; i++)
      decode(i, i % 2 == 1);

    @(negedge clk);
    dec_ready_i = 1'b0;
    #1;
    chk(!dec_valid_o && dec_ready_o, "R3 idle after drain", 64'({dec_valid_o, dec_ready_o}), 64'b01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule